// File: doc/BRIEF.md
# Word-Oriented RISC Execution Core

This block is a single-cycle processor for a compact 32-bit load/store instruction subset. Every clock edge it retires one instruction. It presents the program counter on the instruction fetch port and receives the 32-bit word at that address in the same cycle. It decodes one of three fixed layouts, reads two operands from a 32-entry register file, and computes a result or an effective address. Loads and stores use a word-wide data port. The result is written back and the program counter moves to its next value.

Both memory ports are plain combinational-read, clock-edge-write arrays owned by the surrounding system. Because each transaction completes inside the cycle that issues it, neither port carries a valid/ready handshake and there is no back-pressure. A store is only issued while reset is low and the address is word aligned. A sticky error output reports the first word access whose address has either of its two low bits set.

Bit fields used by decode: opcode in bits 31:26, rs in 25:21, rt in 20:16, rd in 15:11, shift amount in 10:6, function code in 5:0, 16-bit constant in 15:0 and 26-bit jump field in 25:0.

Top module: `rsc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0, clears all 32 registers and clears the error flag; no store is issued while reset is high.
- R2: Register 0 always reads as zero, and any write aimed at it is discarded.
- R3: The fetch address equals the program counter, and the counter advances by 4 each cycle unless a taken branch or a jump redirects it.
- R4: Opcode 0x00 executes the register-register operation selected by the function code and writes rd. The codes are add 0x20, addu 0x21, sub 0x22, subu 0x23, and 0x24, or 0x25, xor 0x26, nor 0x27, signed less-than 0x2A, unsigned less-than 0x2B, shift left 0x00, logical shift right 0x02 and arithmetic shift right 0x03. Shifts act on rt by the shift-amount field.
- R5: The immediate operations write rt. They are add 0x08 and 0x09, signed less-than 0x0A and unsigned less-than 0x0B, which take a sign-extended constant; and 0x0C, or 0x0D and xor 0x0E, which take a zero-extended constant; and 0x0F, which places the constant in the upper half with the lower half zero.
- R6: Opcode 0x23 loads the word at rs plus the sign-extended constant into rt. Opcode 0x2B stores rt to that address.
- R7: Opcodes 0x04 (equal) and 0x05 (not equal) compare rs with rt. When the branch is taken, the next counter is PC+4 plus the sign-extended constant times 4.
- R8: A load or store whose address has a nonzero low two bits issues no store and writes no register. It sets an error output that stays high until reset.
- R9: Opcodes 0x02 and 0x03 jump to the top four bits of PC+4 joined with the 26-bit field times 4. Opcode 0x03 also writes PC+4 into register 31.
- R10: An unrecognised opcode, or an unrecognised function code under opcode 0x00, changes no register, issues no store, and only advances the counter by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction to fetch |
| imem_data | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, written at the next clock edge |
| dmem_rdata | input | 32 | Load data at dmem_addr, same cycle |
| mis_err | output | 1 | Sticky misaligned-access flag |

## Verification
The hardest case to reach from the ports is proving that a misaligned access has no side effect. No register is visible at the ports, so the stimulus first places a misaligned store at an address whose aligned word already holds a known value. It then issues a misaligned load into a register that holds a known value, and afterwards stores that register to a fresh location. Clearing of registers by reset is reached the same way. The program first stores a register, later loads it with a nonzero value, and then the core is reset. The bench overwrites the target word before the rerun, so a surviving value would reappear in memory.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  localparam int XLEN = 32;
  localparam int RIDX = 5;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JMP   = 6'h02;
  localparam logic [5:0] OP_JAL   = 6'h03;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_BNE   = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_ADDIU = 6'h09;
  localparam logic [5:0] OP_SLTI  = 6'h0A;
  localparam logic [5:0] OP_SLTIU = 6'h0B;
  localparam logic [5:0] OP_ANDI  = 6'h0C;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_XORI  = 6'h0E;
  localparam logic [5:0] OP_LUI   = 6'h0F;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_SRL  = 6'h02;
  localparam logic [5:0] FN_SRA  = 6'h03;
  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_XOR  = 6'h26;
  localparam logic [5:0] FN_NOR  = 6'h27;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_NOR,
    ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA, ALU_LUI
  } alu_op_e;

  typedef enum logic { IMM_SIGN, IMM_ZERO } imm_e;

  typedef enum logic [1:0] { WB_ALU, WB_MEM, WB_LINK } wb_e;

  typedef enum logic [1:0] { NX_SEQ, NX_BEQ, NX_BNE, NX_JMP } nx_e;

  typedef struct packed {
    alu_op_e         alu;
    logic            use_imm;
    imm_e            immk;
    logic            wr_en;
    wb_e             wb;
    logic [RIDX-1:0] dst;
    logic            ld;
    logic            st;
    nx_e             nx;
  } ctrl_t;

endpackage

// File: rtl/rsc_decode.sv
module rsc_decode
  import rsc_pkg::*;
#(
  parameter int LINK_REG = 31
) (
  input  logic [5:0]      op,
  input  logic [5:0]      fn,
  input  logic [RIDX-1:0] rt,
  input  logic [RIDX-1:0] rd,
  output ctrl_t           ctrl
);

  localparam logic [RIDX-1:0] LINK_IDX = RIDX'(LINK_REG);

  // register-register group: returns 1 when the function code is known
  function automatic logic rfunc(input logic [5:0] f, output alu_op_e o);
    rfunc = 1'b1;
    o     = ALU_ADD;
    case (f)
      FN_ADD, FN_ADDU: o = ALU_ADD;
      FN_SUB, FN_SUBU: o = ALU_SUB;
      FN_AND:          o = ALU_AND;
      FN_OR:           o = ALU_OR;
      FN_XOR:          o = ALU_XOR;
      FN_NOR:          o = ALU_NOR;
      FN_SLT:          o = ALU_SLT;
      FN_SLTU:         o = ALU_SLTU;
      FN_SLL:          o = ALU_SLL;
      FN_SRL:          o = ALU_SRL;
      FN_SRA:          o = ALU_SRA;
      default:         rfunc = 1'b0;
    endcase
  endfunction

  always_comb begin
    alu_op_e ro;
    logic    known;
    ctrl         = '0;
    ctrl.alu     = ALU_ADD;
    ctrl.immk    = IMM_SIGN;
    ctrl.wb      = WB_ALU;
    ctrl.nx      = NX_SEQ;
    ro           = ALU_ADD;
    known        = 1'b0;
    case (op)
      OP_RTYPE: begin
        known = rfunc(fn, ro);
        if (known) begin
          ctrl.alu   = ro;
          ctrl.wr_en = 1'b1;
          ctrl.dst   = rd;
        end
      end
      OP_ADDI, OP_ADDIU, OP_SLTI, OP_SLTIU,
      OP_ANDI, OP_ORI, OP_XORI, OP_LUI: begin
        ctrl.use_imm = 1'b1;
        ctrl.wr_en   = 1'b1;
        ctrl.dst     = rt;
        case (op)
          OP_SLTI:  ctrl.alu = ALU_SLT;
          OP_SLTIU: ctrl.alu = ALU_SLTU;
          OP_ANDI:  begin ctrl.alu = ALU_AND; ctrl.immk = IMM_ZERO; end
          OP_ORI:   begin ctrl.alu = ALU_OR;  ctrl.immk = IMM_ZERO; end
          OP_XORI:  begin ctrl.alu = ALU_XOR; ctrl.immk = IMM_ZERO; end
          OP_LUI:   begin ctrl.alu = ALU_LUI; ctrl.immk = IMM_ZERO; end
          default:  ctrl.alu = ALU_ADD;
        endcase
      end
      OP_LW: begin
        ctrl.use_imm = 1'b1;
        ctrl.ld      = 1'b1;
        ctrl.wr_en   = 1'b1;
        ctrl.wb      = WB_MEM;
        ctrl.dst     = rt;
      end
      OP_SW: begin
        ctrl.use_imm = 1'b1;
        ctrl.st      = 1'b1;
      end
      OP_BEQ: ctrl.nx = NX_BEQ;
      OP_BNE: ctrl.nx = NX_BNE;
      OP_JMP: ctrl.nx = NX_JMP;
      OP_JAL: begin
        ctrl.nx    = NX_JMP;
        ctrl.wr_en = 1'b1;
        ctrl.wb    = WB_LINK;
        ctrl.dst   = LINK_IDX;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rsc_alu.sv
module rsc_alu
  import rsc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_op_e           op,
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic [RIDX-1:0]   sh,
  output logic [W-1:0]      y
);

  localparam int HALF = W / 2;

  always_comb begin
    case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_XOR:  y = a ^ b;
      ALU_NOR:  y = ~(a | b);
      ALU_SLT:  y = W'($signed(a) < $signed(b));
      ALU_SLTU: y = W'(a < b);
      ALU_SLL:  y = b << sh;
      ALU_SRL:  y = b >> sh;
      ALU_SRA:  y = W'($signed(b) >>> sh);
      ALU_LUI:  y = {b[HALF-1:0], {HALF{1'b0}}};
      default:  y = '0;
    endcase
  end

endmodule

// File: rtl/rsc_regfile.sv
module rsc_regfile
  import rsc_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int NR = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(NR)-1:0]   ra,
  input  logic [$clog2(NR)-1:0]   rb,
  output logic [W-1:0]            qa,
  output logic [W-1:0]            qb,
  input  logic                    we,
  input  logic [$clog2(NR)-1:0]   wa,
  input  logic [W-1:0]            wd
);

  localparam int AW = $clog2(NR);

  logic [W-1:0] regs [NR];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NR; i++) regs[i] <= '0;
    end else if (we && wa != '0) begin
      regs[wa] <= wd;
    end
  end

  assign qa = (ra == AW'(0)) ? '0 : regs[ra];
  assign qb = (rb == AW'(0)) ? '0 : regs[rb];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (we && wa != '0) |=> (regs[$past(wa)] == $past(wd))); // R4

endmodule

// File: rtl/rsc_core.sv
module rsc_core
  import rsc_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0,
  parameter int          LINK_REG = 31
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata,
  output logic        mis_err
);

  localparam int W    = XLEN;
  localparam int NR   = 1 << RIDX;
  localparam int IMMW = 16;
  localparam int JW   = 26;

  logic [W-1:0]    pc_q, pc4, br_tgt, j_tgt, pc_nx;
  logic [5:0]      f_op, f_fn;
  logic [RIDX-1:0] f_rs, f_rt, f_rd, f_sh;
  logic [IMMW-1:0] f_imm;
  logic [JW-1:0]   f_jt;
  ctrl_t           ctrl;
  logic [W-1:0]    rs_v, rt_v, imm_x, opb, alu_y, wb_v;
  logic            mis, rf_we, redirect, err_q;

  assign f_op  = imem_data[31:26];
  assign f_rs  = imem_data[25:21];
  assign f_rt  = imem_data[20:16];
  assign f_rd  = imem_data[15:11];
  assign f_sh  = imem_data[10:6];
  assign f_fn  = imem_data[5:0];
  assign f_imm = imem_data[IMMW-1:0];
  assign f_jt  = imem_data[JW-1:0];

  rsc_decode #(.LINK_REG(LINK_REG)) u_dec (
    .op(f_op), .fn(f_fn), .rt(f_rt), .rd(f_rd), .ctrl(ctrl)
  );

  rsc_regfile #(.W(W), .NR(NR)) u_rf (
    .clk(clk), .rst(rst),
    .ra(f_rs), .rb(f_rt), .qa(rs_v), .qb(rt_v),
    .we(rf_we), .wa(ctrl.dst), .wd(wb_v)
  );

  assign imm_x = (ctrl.immk == IMM_SIGN) ? {{(W-IMMW){f_imm[IMMW-1]}}, f_imm}
                                         : {{(W-IMMW){1'b0}}, f_imm};
  assign opb   = ctrl.use_imm ? imm_x : rt_v;

  rsc_alu #(.W(W)) u_alu (
    .op(ctrl.alu), .a(rs_v), .b(opb), .sh(f_sh), .y(alu_y)
  );

  // data port: effective address comes out of the adder
  assign mis        = (ctrl.ld || ctrl.st) && (alu_y[1:0] != 2'b00);
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_v;
  assign dmem_we    = ctrl.st && !mis && !rst;

  always_comb begin
    case (ctrl.wb)
      WB_MEM:  wb_v = dmem_rdata;
      WB_LINK: wb_v = pc4;
      default: wb_v = alu_y;
    endcase
  end

  assign rf_we = ctrl.wr_en && !(ctrl.ld && mis);

  // sequencing
  assign pc4    = pc_q + 32'd4;
  assign br_tgt = pc4 + {imm_x[W-3:0], 2'b00};
  assign j_tgt  = {pc4[W-1:W-4], f_jt, 2'b00};

  always_comb begin
    redirect = 1'b0;
    pc_nx    = pc4;
    case (ctrl.nx)
      NX_BEQ: if (rs_v == rt_v) begin redirect = 1'b1; pc_nx = br_tgt; end
      NX_BNE: if (rs_v != rt_v) begin redirect = 1'b1; pc_nx = br_tgt; end
      NX_JMP: begin redirect = 1'b1; pc_nx = j_tgt; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= RESET_PC;
      err_q <= 1'b0;
    end else begin
      pc_q  <= pc_nx;
      err_q <= err_q | mis;
    end
  end

  assign imem_addr = pc_q;
  assign mis_err   = err_q;

  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00); // R3
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    !redirect |=> (pc_q == $past(pc_q) + 32'd4)); // R3
  AST_STORE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    dmem_we |-> (dmem_addr[1:0] == 2'b00)); // R8
  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst)
    mis_err |=> mis_err); // R8
  AST_ERR_RISES: assert property (@(posedge clk) disable iff (rst)
    (ctrl.st && dmem_addr[1:0] != 2'b00) |=> mis_err); // R8

endmodule

// File: tb/rsc_core_test.sv
`timescale 1ns/1ps
module rsc_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, mis_err;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic        poke = 1'b0;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  rsc_core uut (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .mis_err(mis_err)
  );

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) begin
    if (poke) dmem[15] <= 32'hDEADBEEF;
    else if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
  end

  // reference model state
  logic [31:0] mr [32];
  logic [31:0] mmem [64];
  logic [31:0] mpc;
  logic        merr;
  // staged results of one model step
  logic [31:0] e_addr, e_wd, n_pc, n_wd;
  logic        e_we, n_err, n_wr;
  logic [4:0]  n_wi;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ri(input logic [5:0] op, input int rs, input int rt, input logic [15:0] k);
    return {op, 5'(rs), 5'(rt), k};
  endfunction
  function automatic logic [31:0] rr(input int rs, input int rt, input int rd, input int sh, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction
  function automatic logic [31:0] rj(input logic [5:0] op, input int t);
    return {op, 26'(t)};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 32; i++) mr[i] = '0;
    mpc  = 32'h0;
    merr = 1'b0;
  endtask

  task automatic model_eval();
    logic [31:0] ins, a, b, se, ze, ad, pc4;
    logic [5:0]  op, fn;
    logic [4:0]  rs, rt, rd, sh;
    ins = imem[mpc[7:2]];
    op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16];
    rd = ins[15:11]; sh = ins[10:6];  fn = ins[5:0];
    a = mr[rs]; b = mr[rt];
    se = {{16{ins[15]}}, ins[15:0]};
    ze = {16'h0, ins[15:0]};
    ad = a + se;
    pc4 = mpc + 4;
    n_pc = pc4; n_err = merr; n_wr = 1'b0; n_wi = 5'd0; n_wd = '0;
    e_we = 1'b0; e_addr = '0; e_wd = '0;
    case (op)
      6'h00: begin
        n_wr = 1'b1; n_wi = rd;
        case (fn)
          6'h20, 6'h21: n_wd = a + b;
          6'h22, 6'h23: n_wd = a - b;
          6'h24: n_wd = a & b;
          6'h25: n_wd = a | b;
          6'h26: n_wd = a ^ b;
          6'h27: n_wd = ~(a | b);
          6'h2A: n_wd = {31'h0, $signed(a) < $signed(b)};
          6'h2B: n_wd = {31'h0, a < b};
          6'h00: n_wd = b << sh;
          6'h02: n_wd = b >> sh;
          6'h03: n_wd = $signed(b) >>> sh;
          default: n_wr = 1'b0;
        endcase
      end
      6'h08, 6'h09: begin n_wr = 1'b1; n_wi = rt; n_wd = a + se; end
      6'h0A: begin n_wr = 1'b1; n_wi = rt; n_wd = {31'h0, $signed(a) < $signed(se)}; end
      6'h0B: begin n_wr = 1'b1; n_wi = rt; n_wd = {31'h0, a < se}; end
      6'h0C: begin n_wr = 1'b1; n_wi = rt; n_wd = a & ze; end
      6'h0D: begin n_wr = 1'b1; n_wi = rt; n_wd = a | ze; end
      6'h0E: begin n_wr = 1'b1; n_wi = rt; n_wd = a ^ ze; end
      6'h0F: begin n_wr = 1'b1; n_wi = rt; n_wd = {ins[15:0], 16'h0}; end
      6'h23: if (ad[1:0] != 0) n_err = 1'b1;
             else begin n_wr = 1'b1; n_wi = rt; n_wd = mmem[ad[7:2]]; end
      6'h2B: if (ad[1:0] != 0) n_err = 1'b1;
             else begin e_we = 1'b1; e_addr = ad; e_wd = b; end
      6'h04: if (a == b) n_pc = pc4 + (se << 2);
      6'h05: if (a != b) n_pc = pc4 + (se << 2);
      6'h02: n_pc = {pc4[31:28], ins[25:0], 2'b00};
      6'h03: begin
        n_pc = {pc4[31:28], ins[25:0], 2'b00};
        n_wr = 1'b1; n_wi = 5'd31; n_wd = pc4;
      end
      default: ;
    endcase
  endtask

  task automatic model_commit();
    if (n_wr && n_wi != 0) mr[n_wi] = n_wd;
    if (e_we) mmem[e_addr[7:2]] = e_wd;
    mpc  = n_pc;
    merr = n_err;
  endtask

  // one clock: compare at the falling edge, then pick the next reset level
  task automatic step(input bit next_rst);
    @(negedge clk);
    model_eval();
    chk(imem_addr, mpc, "R3 fetch address");
    chk({31'h0, mis_err}, {31'h0, merr}, "R8 error flag");
    chk({31'h0, dmem_we}, {31'h0, e_we && !rst}, "R6 store strobe");
    if (e_we && dmem_we) begin
      chk(dmem_addr, e_addr, "R6 store address");
      chk(dmem_wdata, e_wd, "R6 store data");
    end
    rst = next_rst;
    if (next_rst) model_reset();
    else model_commit();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'h0; dmem[i] = 32'h0; mmem[i] = 32'h0;
    end
    imem[0]  = ri(6'h2B, 0, 20, 16'd60);
    imem[1]  = ri(6'h08, 0, 1, 16'd5);
    imem[2]  = ri(6'h08, 0, 2, 16'hFFFD);
    imem[3]  = rr(1, 2, 3, 0, 6'h20);
    imem[4]  = rr(1, 2, 4, 0, 6'h22);
    imem[5]  = ri(6'h08, 0, 0, 16'd7);
    imem[6]  = ri(6'h2B, 0, 3, 16'd0);
    imem[7]  = ri(6'h2B, 0, 4, 16'd4);
    imem[8]  = ri(6'h2B, 0, 0, 16'd8);
    imem[9]  = ri(6'h0F, 0, 5, 16'h1234);
    imem[10] = ri(6'h0D, 5, 5, 16'h8765);
    imem[11] = ri(6'h2B, 0, 5, 16'd12);
    imem[12] = ri(6'h0C, 2, 6, 16'hFFFF);
    imem[13] = ri(6'h2B, 0, 6, 16'd16);
    imem[14] = rr(0, 1, 7, 4, 6'h00);
    imem[15] = rr(0, 2, 8, 1, 6'h03);
    imem[16] = rr(2, 1, 9, 0, 6'h2A);
    imem[17] = rr(2, 1, 10, 0, 6'h2B);
    imem[18] = ri(6'h2B, 0, 7, 16'd20);
    imem[19] = ri(6'h2B, 0, 8, 16'd24);
    imem[20] = ri(6'h2B, 0, 9, 16'd28);
    imem[21] = ri(6'h2B, 0, 10, 16'd32);
    imem[22] = ri(6'h23, 0, 11, 16'd12);
    imem[23] = ri(6'h2B, 0, 11, 16'd36);
    imem[24] = ri(6'h2B, 0, 1, 16'd2);
    imem[25] = ri(6'h23, 0, 11, 16'd5);
    imem[26] = ri(6'h2B, 0, 11, 16'd40);
    imem[27] = 32'hFC00_0000;
    imem[28] = rr(1, 1, 1, 0, 6'h3F);
    imem[29] = ri(6'h2B, 0, 1, 16'd44);
    imem[30] = ri(6'h04, 1, 1, 16'd1);
    imem[31] = ri(6'h08, 0, 12, 16'd99);
    imem[32] = ri(6'h05, 1, 1, 16'd1);
    imem[33] = ri(6'h08, 12, 12, 16'd1);
    imem[34] = ri(6'h2B, 0, 12, 16'd48);
    imem[35] = rj(6'h03, 37);
    imem[36] = ri(6'h08, 0, 12, 16'd77);
    imem[37] = ri(6'h2B, 0, 31, 16'd52);
    imem[38] = ri(6'h08, 0, 20, 16'd33);
    imem[39] = rj(6'h02, 39);

    model_reset();
    step(1'b1);
    @(negedge clk);
    chk(imem_addr, 32'h0, "R1 counter after reset");
    chk({31'h0, dmem_we}, 32'h0, "R1 no store in reset");
    rst = 1'b0;
    model_reset();
    model_eval();
    model_commit();

    for (int c = 0; c < 60; c++) step(1'b0);

    chk(dmem[0],  32'h0000_0002, "R4 add");
    chk(dmem[1],  32'h0000_0008, "R4 sub");
    chk(dmem[2],  32'h0000_0000, "R2 write to r0 discarded");
    chk(dmem[3],  32'h1234_8765, "R5 upper then or");
    chk(dmem[4],  32'h0000_FFFD, "R5 zero-extended and");
    chk(dmem[5],  32'h0000_0050, "R4 shift left");
    chk(dmem[6],  32'hFFFF_FFFE, "R4 arithmetic shift right");
    chk(dmem[7],  32'h0000_0001, "R4 signed less-than");
    chk(dmem[8],  32'h0000_0000, "R4 unsigned less-than");
    chk(dmem[9],  32'h1234_8765, "R6 load then store");
    chk(dmem[10], 32'h1234_8765, "R8 misaligned load kept register");
    chk(dmem[11], 32'h0000_0005, "R10 unknown opcode and function");
    chk(dmem[12], 32'h0000_0001, "R7 branch taken and not taken");
    chk(dmem[13], 32'h0000_0090, "R9 link register");
    chk(imem_addr, 32'h0000_009C, "R9 jump to self");
    chk({31'h0, mis_err}, 32'h1, "R8 sticky error");
    for (int i = 0; i < 16; i++) chk(dmem[i], mmem[i], "R6 memory image");

    // reset again after overwriting the word that r20 lands in
    @(negedge clk);
    poke = 1'b1;
    rst  = 1'b1;
    mmem[15] = 32'hDEADBEEF;
    model_reset();
    @(negedge clk);
    poke = 1'b0;
    chk(imem_addr, 32'h0, "R1 counter after second reset");
    chk({31'h0, mis_err}, 32'h0, "R1 error cleared");
    chk(dmem[15], 32'hDEADBEEF, "R1 no store in reset");
    rst = 1'b0;
    model_eval();
    model_commit();
    for (int c = 0; c < 12; c++) step(1'b0);
    chk(dmem[15], 32'h0, "R1 registers cleared by reset");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule